// File: doc/BRIEF.md
# Almost-Empty Status Bus Scanner

This block decides when one queue device in a chain may place its per-queue almost-empty flags on a shared status bus, and it drives that bus. The flags themselves come from flag logic elsewhere. The block only registers the flags and gates them onto the bus. A mode input is sampled while reset is held, and it fixes one of two ways of sharing the bus.

In direct mode, a host raises a select strobe together with a device address. The device whose address parameter matches takes the bus on that read-clock edge. Every other device releases it. Selections are refused while the programming-busy input is high.

In polled mode, a single token circulates around a ring of devices. The holder drives the bus for one read-clock cycle. It raises its sync and token outputs for that cycle, and the next device in the ring takes over at the following edge. The device marked as first holds the token as reset is released. A lone device closes the ring on itself and then owns the bus in every cycle.

Top module: `qscan_top`

## Requirements
- R1: A high mode input while reset is low selects polled mode. A low mode input selects direct mode. Changing the mode input after reset has no effect on behaviour.
- R2: In direct mode, a rising read-clock edge with the strobe high and programming-busy low makes the device own the bus from that edge on, if the address equals the device address. Otherwise the device releases the bus.
- R3: In direct mode, a strobe seen while programming-busy is high changes no ownership.
- R4: In direct mode, without a strobe, ownership holds from edge to edge.
- R5: In direct mode, the sync and token outputs stay low and the token input has no effect.
- R6: In polled mode, the device owns the bus in a cycle exactly when its token input was high at the edge that began the cycle. The strobe is ignored.
- R7: In polled mode, the sync and token outputs are high exactly in the cycles in which the device owns the bus. In a two-device ring, ownership alternates every cycle.
- R8: After reset in polled mode, a device whose first-in-chain parameter is set owns the bus in the first cycle. A device without it does not.
- R9: The output enable is high exactly when the device owns the bus. While it is high, the bus shows the flags sampled at the edge that began the cycle. While it is low, the bus is all zeros.
- R10: After reset in direct mode, the output enable, sync, token and bus outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rd | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pin_i | input | 1 | Mode selection sampled in reset: 1 polled, 0 direct |
| prog_busy_i | input | 1 | High while programming is still in progress |
| sel_stb_i | input | 1 | Direct-mode select strobe |
| sel_addr_i | input | ADDR_W | Direct-mode device address |
| tok_in_i | input | 1 | Token from the previous device in the ring |
| tok_out_o | output | 1 | Token to the next device in the ring |
| sync_o | output | 1 | High while this device's status is on the bus (polled mode) |
| flags_i | input | NQ | Per-queue almost-empty flags from the flag logic |
| stat_bus_o | output | NQ | Status bus value |
| stat_oe_o | output | 1 | Bus output enable; models the tri-state drive |

## Verification
The assertions assume that the mode input is only relevant while reset is held. They also assume that in polled mode the token input is a single device's token, so ownership can be traced to the token input one edge earlier. The bench changes the mode input after reset only to show that it is ignored. It drives the token input from its own stimulus only in single-device patterns, and otherwise closes a two-device ring from the devices' own token outputs. All inputs change one nanosecond after a rising edge, and outputs are sampled there as well.

// File: rtl/qscan_pkg.sv
// Package: qscan_pkg
// Shared types for the status bus scanner: the bus-sharing mode.
package qscan_pkg;
    typedef enum logic {
        SCAN_DIRECT = 1'b0,
        SCAN_POLLED = 1'b1
    } scan_mode_e;
endpackage

// File: rtl/qscan_mode_latch.sv
// Module: qscan_mode_latch
// Captures the mode input while reset is low and holds it afterwards.
// Assumes the mode input is settled during reset.
module qscan_mode_latch
    import qscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_pin,
    output scan_mode_e mode
);
    scan_mode_e mode_q;

    // Sample the mode input on every reset edge; freeze it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= scan_mode_e'(mode_pin);
        end
    end

    assign mode = mode_q;

    // R1
    mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/qscan_direct_sel.sv
// Module: qscan_direct_sel
// Direct-mode ownership: a strobe with a matching address claims the bus,
// a strobe with any other address releases it. Strobes are refused while
// programming is busy. Assumes the enable is constant after reset.
module qscan_direct_sel #(
    parameter int ADDR_W   = 3,
    parameter int DEV_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              prog_busy,
    input  logic              stb,
    input  logic [ADDR_W-1:0] addr,
    output logic              owner
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DEV_ADDR);

    logic owner_q;
    logic take;

    // Decide whether this edge carries an accepted selection.
    always_comb begin
        take = enable && stb && !prog_busy;
    end

    // Update ownership on an accepted selection, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= 1'b0;
        end else if (!enable) begin
            owner_q <= 1'b0;
        end else if (take) begin
            owner_q <= (addr == MY_ADDR);
        end
    end

    assign owner = owner_q;

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(prog_busy)) |-> $stable(owner_q));

    // R4
    no_stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stb)) |-> $stable(owner_q));
endmodule

// File: rtl/qscan_token_stage.sv
// Module: qscan_token_stage
// Polled-mode token register. It loads the token input each edge. The
// first device of a ring comes out of reset holding the token.
// Assumes a ring of devices that carries a single token.
module qscan_token_stage #(
    parameter bit IS_FIRST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_pin,
    input  logic enable,
    input  logic tok_in,
    output logic hold
);
    logic hold_q;

    // Seed the token at reset; afterwards pass it along from the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= IS_FIRST & mode_pin;
        end else begin
            hold_q <= enable & tok_in;
        end
    end

    assign hold = hold_q;

    // R6
    polled_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && enable) |-> (hold_q == $past(tok_in)));
endmodule

// File: rtl/qscan_bus_drive.sv
// Module: qscan_bus_drive
// Registers the flags every edge and gates them onto the bus while owned.
// Assumes the flags are synchronous to the read clock.
module qscan_bus_drive #(
    parameter int NQ = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          own,
    input  logic [NQ-1:0] flags,
    output logic [NQ-1:0] bus,
    output logic          oe
);
    logic [NQ-1:0] flags_q;

    // Capture the flags on every edge so a new owner shows fresh status.
    always_ff @(posedge clk) begin
        flags_q <= flags;
    end

    // Drive the bus only while owned; otherwise present zeros.
    always_comb begin
        oe  = own;
        bus = own ? flags_q : '0;
    end

    // R9
    bus_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && oe) |-> (bus == $past(flags)));

    // R9
    bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (bus == '0));
endmodule

// File: rtl/qscan_top.sv
// Module: qscan_top
// Almost-empty status bus scanner for one device of a chain. It combines
// the reset-time mode latch, the direct selector, the token stage and the
// bus driver. Assumes the mode input is settled during reset.
module qscan_top
    import qscan_pkg::*;
#(
    parameter int NQ       = 4,
    parameter int ADDR_W   = 3,
    parameter int DEV_ADDR = 0,
    parameter bit IS_FIRST = 1'b1
) (
    input  logic              clk_rd,
    input  logic              rst_n,
    input  logic              mode_pin_i,
    input  logic              prog_busy_i,
    input  logic              sel_stb_i,
    input  logic [ADDR_W-1:0] sel_addr_i,
    input  logic              tok_in_i,
    output logic              tok_out_o,
    output logic              sync_o,
    input  logic [NQ-1:0]     flags_i,
    output logic [NQ-1:0]     stat_bus_o,
    output logic              stat_oe_o
);
    scan_mode_e mode;
    logic       polled;
    logic       dir_own;
    logic       tok_hold;
    logic       own;

    qscan_mode_latch u_mode (
        .clk      (clk_rd),
        .rst_n    (rst_n),
        .mode_pin (mode_pin_i),
        .mode     (mode)
    );

    // Decode the mode and choose the owner source.
    always_comb begin
        polled = (mode == SCAN_POLLED);
        own    = polled ? tok_hold : dir_own;
    end

    qscan_direct_sel #(
        .ADDR_W   (ADDR_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_dsel (
        .clk       (clk_rd),
        .rst_n     (rst_n),
        .enable    (!polled),
        .prog_busy (prog_busy_i),
        .stb       (sel_stb_i),
        .addr      (sel_addr_i),
        .owner     (dir_own)
    );

    qscan_token_stage #(
        .IS_FIRST (IS_FIRST)
    ) u_tok (
        .clk      (clk_rd),
        .rst_n    (rst_n),
        .mode_pin (mode_pin_i),
        .enable   (polled),
        .tok_in   (tok_in_i),
        .hold     (tok_hold)
    );

    qscan_bus_drive #(
        .NQ (NQ)
    ) u_bus (
        .clk   (clk_rd),
        .rst_n (rst_n),
        .own   (own),
        .flags (flags_i),
        .bus   (stat_bus_o),
        .oe    (stat_oe_o)
    );

    // Announce the turn and hand the token on while holding it.
    always_comb begin
        sync_o    = polled & tok_hold;
        tok_out_o = polled & tok_hold;
    end

    // R5
    direct_quiet_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        !polled |-> (!sync_o && !tok_out_o));

    // R7
    sync_own_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        polled |-> (sync_o == stat_oe_o));
endmodule

// File: tb/qscan_top_test.sv
// Directed bench: two scanner instances (addresses 5 and 6), where the
// first is marked first-in-chain. Inputs change and outputs are sampled
// 1 ns after each rising edge.
module qscan_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_pin = 1'b0;
    logic       busy = 1'b1;
    logic       stb = 1'b0;
    logic [2:0] addr = '0;
    logic       ext_tok = 1'b0;
    logic       ring = 1'b0;
    logic [3:0] flags_a = '0;
    logic [3:0] flags_b = '0;
    logic       tok_a, tok_b, sync_a, sync_b, oe_a, oe_b, tin_a;
    logic [3:0] bus_a, bus_b;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    assign tin_a = ring ? tok_b : ext_tok;

    qscan_top #(.NQ(4), .ADDR_W(3), .DEV_ADDR(5), .IS_FIRST(1'b1)) uut (
        .clk_rd(clk), .rst_n(rst_n), .mode_pin_i(mode_pin), .prog_busy_i(busy),
        .sel_stb_i(stb), .sel_addr_i(addr), .tok_in_i(tin_a), .tok_out_o(tok_a),
        .sync_o(sync_a), .flags_i(flags_a), .stat_bus_o(bus_a), .stat_oe_o(oe_a));

    qscan_top #(.NQ(4), .ADDR_W(3), .DEV_ADDR(6), .IS_FIRST(1'b0)) uut_next (
        .clk_rd(clk), .rst_n(rst_n), .mode_pin_i(mode_pin), .prog_busy_i(busy),
        .sel_stb_i(stb), .sel_addr_i(addr), .tok_in_i(tok_a), .tok_out_o(tok_b),
        .sync_o(sync_b), .flags_i(flags_b), .stat_bus_o(bus_b), .stat_oe_o(oe_b));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic m);
        mode_pin = m; ring = 1'b0; ext_tok = 1'b0; stb = 1'b0; busy = 1'b1;
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset_direct();
        flags_a = 4'hF;
        do_reset(1'b0);
        check("R10 oe_a", oe_a, 0);
        check("R10 sync_a", sync_a, 0);
        check("R10 tok_a", tok_a, 0);
        check("R10 bus_a", bus_a, 0);
        check("R10 oe_b", oe_b, 0);
    endtask

    task automatic t_direct_select();
        busy = 1'b0; flags_a = 4'hA; stb = 1'b1; addr = 3'd5;
        step();
        check("R2 oe_a on match", oe_a, 1);
        check("R9 bus_a data", bus_a, 4'hA);
        check("R2 oe_b mismatch", oe_b, 0);
        stb = 1'b0; flags_a = 4'h3;
        step();
        check("R4 oe_a held", oe_a, 1);
        check("R9 bus_a follows flags", bus_a, 4'h3);
        stb = 1'b1; addr = 3'd6;
        step();
        check("R2 oe_a released", oe_a, 0);
        check("R9 bus_a idle zero", bus_a, 0);
        check("R2 oe_b selected", oe_b, 1);
        addr = 3'd2;
        step();
        check("R2 oe_a none", oe_a, 0);
        check("R2 oe_b none", oe_b, 0);
        stb = 1'b0;
    endtask

    task automatic t_direct_busy();
        stb = 1'b1; addr = 3'd5; busy = 1'b0;
        step();
        check("R2 oe_a claim", oe_a, 1);
        busy = 1'b1; addr = 3'd6;
        step();
        check("R3 oe_a kept while busy", oe_a, 1);
        check("R3 oe_b refused while busy", oe_b, 0);
        stb = 1'b0; busy = 1'b0;
    endtask

    task automatic t_direct_token();
        ext_tok = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R5 sync_a low", sync_a, 0);
            check("R5 tok_a low", tok_a, 0);
            check("R5 oe_a unchanged", oe_a, 1);
            check("R5 oe_b unchanged", oe_b, 0);
        end
        ext_tok = 1'b0;
    endtask

    task automatic t_polled_first();
        flags_a = 4'h5;
        do_reset(1'b1);
        busy = 1'b0;
        check("R8 oe_a first", oe_a, 1);
        check("R7 sync_a first", sync_a, 1);
        check("R7 tok_a first", tok_a, 1);
        check("R9 bus_a first", bus_a, 4'h5);
        check("R8 oe_b not first", oe_b, 0);
        check("R7 sync_b not first", sync_b, 0);
        step();
        check("R6 oe_a no token", oe_a, 0);
        check("R7 sync_a no token", sync_a, 0);
        check("R6 oe_b took token", oe_b, 1);
        check("R7 sync_b took token", sync_b, 1);
        check("R7 tok_b took token", tok_b, 1);
        step();
        check("R6 oe_a idle", oe_a, 0);
        check("R6 oe_b idle", oe_b, 0);
    endtask

    task automatic t_polled_ext();
        ext_tok = 1'b1; flags_a = 4'h9;
        step();
        check("R6 oe_a token in", oe_a, 1);
        check("R7 sync_a token in", sync_a, 1);
        check("R9 bus_a polled", bus_a, 4'h9);
        ext_tok = 1'b0; stb = 1'b1; addr = 3'd5;
        step();
        check("R6 strobe ignored oe_a", oe_a, 0);
        check("R6 oe_b next", oe_b, 1);
        step();
        check("R6 strobe ignored oe_a again", oe_a, 0);
        check("R6 oe_b done", oe_b, 0);
        stb = 1'b0;
    endtask

    task automatic t_ring();
        do_reset(1'b1);
        busy = 1'b0; ring = 1'b1;
        for (int i = 0; i < 6; i++) begin
            check("R7 ring oe_a", oe_a, (i % 2 == 0) ? 1 : 0);
            check("R7 ring oe_b", oe_b, (i % 2 == 0) ? 0 : 1);
            check("R7 ring sync_a", sync_a, (i % 2 == 0) ? 1 : 0);
            if (i == 1) mode_pin = 1'b0;
            step();
        end
        check("R1 mode pin ignored oe_a", oe_a, 1);
        check("R1 mode pin ignored sync_a", sync_a, 1);
        check("R1 mode pin ignored oe_b", oe_b, 0);
        ring = 1'b0;
    endtask

    task automatic t_mode_latched_direct();
        do_reset(1'b0);
        mode_pin = 1'b1; busy = 1'b0; ext_tok = 1'b1;
        step(); step();
        check("R1 direct kept sync_a", sync_a, 0);
        check("R1 direct kept oe_a", oe_a, 0);
        stb = 1'b1; addr = 3'd5;
        step();
        check("R1 direct strobe works", oe_a, 1);
        stb = 1'b0; ext_tok = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        t_reset_direct();
        t_direct_select();
        t_direct_busy();
        t_direct_token();
        t_polled_first();
        t_polled_ext();
        t_ring();
        t_mode_latched_direct();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule